// File: doc/BRIEF.md
# Sticky Status Register Bank

This block gathers the fault and monitor events of a two-channel driver controller and presents them to a host through a byte-wide read port. Transient events such as overcurrent, output-stage saturation, supply-rail power-down, oscillator watchdog expiry and configuration-mode timeout are caught in sticky flags. A flag stays set until the host reads the byte that holds it, and the read then clears it. The same bytes also carry the live level of each channel's monitor pin, so one read returns both "is it high now" and "was it high since the last look".

The bank also returns an 8-bit temperature code and two 10-bit conversion results. Each result is split across a low and a high byte address. Reading a low byte freezes the upper bits of that result, so a following read of the high byte belongs to the same sample. A merge input changes the meaning of the two rail power-down flags. With merge on, one flag reports that the rail voltages disagree and the other reports a power-down on either rail.

Reads are strobed. The data appears on the registered output one clock after the strobe, and the output is zero in every cycle without a strobe.

Top module: `status_bank`

## Requirements
- R1: After reset all sticky flags are clear, `rd_data` is 0x00, `laser_off` is low and both conversion snapshots hold zero.
- R2: Byte 0x00 holds sticky flags: channel-2 overcurrent in bit 4, channel-1 overcurrent in bit 5 and oscillator watchdog in bit 6. Bits 3:0 read as zero. An event sets its flag, and only a read of 0x00 clears it.
- R3: Bit 7 of byte 0x00 is set only when `cfg_expire` is high while `cfg_mode` is high. `laser_off` is high exactly while that flag is set, and the flag clears on a read of 0x00.
- R4: Byte 0x01 bits 0 and 4 return the levels of `mon1` and `mon2` in the strobe cycle. They are not latched.
- R5: Byte 0x01 bits 1 and 5 are sticky. They are set whenever `mon1` or `mon2`, respectively, is high, and a read of 0x01 clears them.
- R6: Byte 0x01 bits 2 and 6 are sticky saturation flags for channel 1 and channel 2, cleared by a read of 0x01.
- R7: With `merge_en` low, byte 0x01 bit 3 latches `rail1_down` and bit 7 latches `rail2_down`. `rail_mismatch` has no effect.
- R8: With `merge_en` high, byte 0x01 bit 3 latches `rail_mismatch` and bit 7 latches `rail1_down` OR `rail2_down`. A read of 0x01 clears both.
- R9: If an event is high in the same cycle as the read that clears its flag, that read returns the old value and the flag is set again, so the next read shows it.
- R10: Byte 0x02 returns the temperature code unchanged, from 0x00 up to 0xFF.
- R11: Conversion channel 1 uses addresses 0x03 (low) and 0x04 (high), and channel 2 uses 0x05 and 0x06. The low byte returns bits 7:0 of the live value and captures bits 9:8. The high byte returns the captured bits in bits 1:0, with bits 7:2 zero.
- R12: Addresses 0x07 to 0xFF read as 0x00 and clear nothing.
- R13: `rd_data` carries the addressed byte in the cycle after `rd_en` and is 0x00 in every cycle after a cycle without `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_en | input | 1 | Read strobe, one byte per cycle |
| rd_addr | input | 8 | Byte address of the read |
| rd_data | output | 8 | Registered read data |
| laser_off | output | 1 | Output shutdown request after a configuration timeout |
| ovc1 | input | 1 | Channel-1 overcurrent event |
| ovc2 | input | 1 | Channel-2 overcurrent event |
| osc_wdt | input | 1 | Oscillator watchdog expiry |
| cfg_mode | input | 1 | Device is in configuration mode |
| cfg_expire | input | 1 | Configuration timer expired |
| mon1 | input | 1 | Channel-1 monitor pin level |
| mon2 | input | 1 | Channel-2 monitor pin level |
| sat1 | input | 1 | Channel-1 output stage saturated |
| sat2 | input | 1 | Channel-2 output stage saturated |
| rail1_down | input | 1 | Supply rail 1 power-down event |
| rail2_down | input | 1 | Supply rail 2 power-down event |
| rail_mismatch | input | 1 | Rail voltages differ (used in merge mode) |
| merge_en | input | 1 | Merge mode for the rail flags |
| temp_code | input | 8 | Temperature code |
| adc1_val | input | 10 | Conversion result, channel 1 |
| adc2_val | input | 10 | Conversion result, channel 2 |

## Verification
The assertions check, on every cycle, several single-step rules. An event always leaves its flag set one cycle later, even under a clearing read. A clearing read without an event leaves the flag low. `laser_off` rises only after configuration mode and follows a timeout. Idle and unused-address cycles return zero, the upper six bits of a high conversion byte are zero, and the live monitor bit matches the pin. The bench scenarios show the end-to-end effects that span several transactions. These are the clear-then-re-set sequence of a same-cycle event, the coherence of a high conversion byte after the live value changes, the swap of rail meanings under merge mode, and the fact that reads of other addresses leave flags untouched.

// File: rtl/status_pkg.sv
package status_pkg;

  localparam int ADDR_W = 8;

  // byte addresses
  localparam logic [ADDR_W-1:0] A_FAULT = 8'h00;
  localparam logic [ADDR_W-1:0] A_CHAN  = 8'h01;
  localparam logic [ADDR_W-1:0] A_TEMP  = 8'h02;
  localparam logic [ADDR_W-1:0] A_CONV0 = 8'h03;  // channel k low at A_CONV0+2k, high at +1

  // sticky flag indices
  localparam int F_OVC2 = 0;
  localparam int F_OVC1 = 1;
  localparam int F_OSC  = 2;
  localparam int F_CFG  = 3;
  localparam int F_MON1 = 4;
  localparam int F_SAT1 = 5;
  localparam int F_PD1  = 6;
  localparam int F_MON2 = 7;
  localparam int F_SAT2 = 8;
  localparam int F_PD2  = 9;
  localparam int N_FLAGS = 10;

  localparam logic [N_FLAGS-1:0] FAULT_MASK = 10'b00_0000_1111;
  localparam logic [N_FLAGS-1:0] CHAN_MASK  = 10'b11_1111_0000;

  function automatic logic [7:0] pack_fault(input logic [N_FLAGS-1:0] q);
    return {q[F_CFG], q[F_OSC], q[F_OVC1], q[F_OVC2], 4'b0000};
  endfunction

  function automatic logic [7:0] pack_chan(input logic [N_FLAGS-1:0] q,
                                           input logic lvl1, input logic lvl2);
    return {q[F_PD2], q[F_SAT2], q[F_MON2], lvl2,
            q[F_PD1], q[F_SAT1], q[F_MON1], lvl1};
  endfunction

endpackage

// File: rtl/status_event_map.sv
module status_event_map
  import status_pkg::*;
(
  input  logic               ovc1,
  input  logic               ovc2,
  input  logic               osc_wdt,
  input  logic               cfg_mode,
  input  logic               cfg_expire,
  input  logic               mon1,
  input  logic               mon2,
  input  logic               sat1,
  input  logic               sat2,
  input  logic               rail1_down,
  input  logic               rail2_down,
  input  logic               rail_mismatch,
  input  logic               merge_en,
  output logic [N_FLAGS-1:0] ev
);
  always_comb begin
    ev         = '0;
    ev[F_OVC1] = ovc1;
    ev[F_OVC2] = ovc2;
    ev[F_OSC]  = osc_wdt;
    ev[F_CFG]  = cfg_mode & cfg_expire;
    ev[F_MON1] = mon1;
    ev[F_MON2] = mon2;
    ev[F_SAT1] = sat1;
    ev[F_SAT2] = sat2;
    ev[F_PD1]  = merge_en ? rail_mismatch : rail1_down;
    ev[F_PD2]  = merge_en ? (rail1_down | rail2_down) : rail2_down;
  end
endmodule

// File: rtl/sticky_bank.sv
module sticky_bank #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q_o[i] <= 1'b0;
      else if (set_i[i])   q_o[i] <= 1'b1;   // set beats clear
      else if (clr_i[i])   q_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/conv_split.sv
module conv_split #(
  parameter int VAL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [VAL_W-1:0] val,
  output logic [7:0]       lo_byte,
  output logic [7:0]       hi_byte
);
  localparam int HI_W  = VAL_W - 8;
  localparam int PAD_W = 8 - HI_W;

  logic [HI_W-1:0] snap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       snap_q <= '0;
    else if (capture) snap_q <= val[VAL_W-1:8];
  end

  assign lo_byte = val[7:0];
  assign hi_byte = {{PAD_W{1'b0}}, snap_q};
endmodule

// File: rtl/status_bank.sv
module status_bank
  import status_pkg::*;
#(
  parameter int TEMP_W = 8,
  parameter int CONV_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              laser_off,
  input  logic              ovc1,
  input  logic              ovc2,
  input  logic              osc_wdt,
  input  logic              cfg_mode,
  input  logic              cfg_expire,
  input  logic              mon1,
  input  logic              mon2,
  input  logic              sat1,
  input  logic              sat2,
  input  logic              rail1_down,
  input  logic              rail2_down,
  input  logic              rail_mismatch,
  input  logic              merge_en,
  input  logic [TEMP_W-1:0] temp_code,
  input  logic [CONV_W-1:0] adc1_val,
  input  logic [CONV_W-1:0] adc2_val
);
  localparam int N_CONV = 2;

  logic [N_FLAGS-1:0] flag_set;
  logic [N_FLAGS-1:0] flag_clr;
  logic [N_FLAGS-1:0] flag_q;
  logic               rd_fault;
  logic               rd_chan;
  logic [7:0]         conv_lo [N_CONV];
  logic [7:0]         conv_hi [N_CONV];
  logic [CONV_W-1:0]  conv_val [N_CONV];
  logic [7:0]         rd_mux;

  status_event_map u_map (
    .ovc1, .ovc2, .osc_wdt, .cfg_mode, .cfg_expire, .mon1, .mon2,
    .sat1, .sat2, .rail1_down, .rail2_down, .rail_mismatch, .merge_en,
    .ev(flag_set)
  );

  assign rd_fault = rd_en && (rd_addr == A_FAULT);
  assign rd_chan  = rd_en && (rd_addr == A_CHAN);
  assign flag_clr = (rd_fault ? FAULT_MASK : '0) | (rd_chan ? CHAN_MASK : '0);

  sticky_bank #(.N(N_FLAGS)) u_flags (
    .clk, .rst_n, .set_i(flag_set), .clr_i(flag_clr), .q_o(flag_q)
  );

  assign conv_val[0] = adc1_val;
  assign conv_val[1] = adc2_val;

  for (genvar k = 0; k < N_CONV; k++) begin : g_conv
    localparam logic [ADDR_W-1:0] LO_A = A_CONV0 + ADDR_W'(2 * k);
    conv_split #(.VAL_W(CONV_W)) u_conv (
      .clk, .rst_n,
      .capture(rd_en && (rd_addr == LO_A)),
      .val(conv_val[k]),
      .lo_byte(conv_lo[k]),
      .hi_byte(conv_hi[k])
    );
  end

  always_comb begin
    rd_mux = 8'h00;
    unique case (rd_addr)
      A_FAULT:         rd_mux = pack_fault(flag_q);
      A_CHAN:          rd_mux = pack_chan(flag_q, mon1, mon2);
      A_TEMP:          rd_mux = 8'(temp_code);
      A_CONV0:         rd_mux = conv_lo[0];
      A_CONV0 + 8'd1:  rd_mux = conv_hi[0];
      A_CONV0 + 8'd2:  rd_mux = conv_lo[1];
      A_CONV0 + 8'd3:  rd_mux = conv_hi[1];
      default:         rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= 8'h00;
    else        rd_data <= rd_en ? rd_mux : 8'h00;
  end

  assign laser_off = flag_q[F_CFG];

endmodule

// File: rtl/status_bank_chk.sv
module status_bank_chk
  import status_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               rd_en,
  input logic [ADDR_W-1:0]  rd_addr,
  input logic [7:0]         rd_data,
  input logic               laser_off,
  input logic               cfg_mode,
  input logic               cfg_expire,
  input logic               mon1,
  input logic               merge_en,
  input logic               rail1_down,
  input logic               rail2_down,
  input logic [N_FLAGS-1:0] flag_set,
  input logic [N_FLAGS-1:0] flag_clr,
  input logic [N_FLAGS-1:0] flag_q
);
  p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_set[F_OVC1] && flag_clr[F_OVC1]) |=> flag_q[F_OVC1]);

  p_clear_on_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr[F_OSC] && !flag_set[F_OSC]) |=> !flag_q[F_OSC]);

  p_timeout_shuts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode && cfg_expire) |=> laser_off);

  p_shut_needs_cfg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(laser_off) |-> $past(cfg_mode));

  p_idle_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rd_data == 8'h00));

  p_unused_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr > 8'h06) |=> (rd_data == 8'h00));

  p_conv_hi_pad_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (rd_addr == 8'h04 || rd_addr == 8'h06)) |=> (rd_data[7:2] == 6'b0));

  p_live_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == A_CHAN) |=> (rd_data[0] == $past(mon1)));

  p_merge_or_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (merge_en && (rail1_down || rail2_down)) |=> flag_q[F_PD2]);
endmodule

bind status_bank status_bank_chk u_chk (
  .clk, .rst_n, .rd_en, .rd_addr, .rd_data, .laser_off, .cfg_mode,
  .cfg_expire, .mon1, .merge_en, .rail1_down, .rail2_down,
  .flag_set, .flag_clr, .flag_q
);

// File: tb/status_bank_test.sv
module status_bank_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_addr = 8'h00;
  logic [7:0] rd_data;
  logic       laser_off;
  logic ovc1 = 0, ovc2 = 0, osc_wdt = 0, cfg_mode = 0, cfg_expire = 0;
  logic mon1 = 0, mon2 = 0, sat1 = 0, sat2 = 0;
  logic rail1_down = 0, rail2_down = 0, rail_mismatch = 0, merge_en = 0;
  logic [7:0] temp_code = 8'h00;
  logic [9:0] adc1_val = 10'h000;
  logic [9:0] adc2_val = 10'h000;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  typedef struct {
    logic [7:0] addr;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t scb[$];
  logic  exp_due = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  status_bank uut (
    .clk, .rst_n, .rd_en, .rd_addr, .rd_data, .laser_off,
    .ovc1, .ovc2, .osc_wdt, .cfg_mode, .cfg_expire, .mon1, .mon2,
    .sat1, .sat2, .rail1_down, .rail2_down, .rail_mismatch, .merge_en,
    .temp_code, .adc1_val, .adc2_val
  );

  // monitor: a read strobed at edge N shows on rd_data from edge N on
  always @(posedge clk) exp_due <= rd_en;

  always @(negedge clk) begin
    if (exp_due && scb.size() > 0) begin
      item_t it;
      it = scb.pop_front();
      n_checks++;
      if (rd_data !== it.exp) begin
        n_fails++;
        $display("FAIL %s: addr %02h actual %02h expected %02h",
                 it.tag, it.addr, rd_data, it.exp);
      end
    end
  end

  task automatic do_read(input logic [7:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    rd_en   = 1'b1;
    rd_addr = a;
    scb.push_back('{addr: a, exp: e, tag: tag});
    @(negedge clk);
    rd_en   = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_bit(input logic act, input logic e, input string tag);
    n_checks++;
    if (act !== e) begin
      n_fails++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, e);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    check_bit(rd_data == 8'h00, 1'b1, "R1 rd_data after reset");
    check_bit(laser_off, 1'b0, "R1 laser_off after reset");
    do_read(8'h00, 8'h00, "R1 fault byte");
    do_read(8'h01, 8'h00, "R1 chan byte");
    do_read(8'h04, 8'h00, "R1 conv1 snapshot");

    // R2 fault flags and clear on read
    tick(); ovc1 = 1; tick(); ovc1 = 0;
    do_read(8'h01, 8'h00, "R2 other byte does not clear");
    do_read(8'h00, 8'h20, "R2 ovc1 bit5");
    do_read(8'h00, 8'h00, "R2 cleared");
    ovc2 = 1; osc_wdt = 1; tick(); ovc2 = 0; osc_wdt = 0;
    do_read(8'h00, 8'h50, "R2 ovc2 bit4 osc bit6");

    // R3 configuration timeout
    cfg_expire = 1; tick(); cfg_expire = 0; tick();
    check_bit(laser_off, 1'b0, "R3 expiry outside cfg mode");
    do_read(8'h00, 8'h00, "R3 no flag outside cfg mode");
    cfg_mode = 1; cfg_expire = 1; tick(); cfg_expire = 0; cfg_mode = 0; tick();
    check_bit(laser_off, 1'b1, "R3 laser_off set");
    do_read(8'h00, 8'h80, "R3 flag bit7");
    check_bit(laser_off, 1'b0, "R3 laser_off cleared by read");

    // R4 / R5 monitor pins
    mon1 = 1; tick();
    do_read(8'h01, 8'h03, "R4 R5 mon1 live and sticky");
    mon1 = 0; tick();
    do_read(8'h01, 8'h02, "R5 sticky after live low");
    do_read(8'h01, 8'h00, "R5 cleared");
    mon2 = 1; tick();
    do_read(8'h01, 8'h30, "R4 R5 mon2");
    mon2 = 0; tick();
    do_read(8'h01, 8'h20, "R5 mon2 re-set while high");
    do_read(8'h01, 8'h00, "R5 mon2 cleared");

    // R6 saturation
    sat1 = 1; sat2 = 1; tick(); sat1 = 0; sat2 = 0;
    do_read(8'h01, 8'h44, "R6 saturation bits");

    // R7 merge off
    rail_mismatch = 1; tick(); rail_mismatch = 0;
    do_read(8'h01, 8'h00, "R7 mismatch ignored");
    rail1_down = 1; tick(); rail1_down = 0;
    do_read(8'h01, 8'h08, "R7 rail1 bit3");
    rail2_down = 1; tick(); rail2_down = 0;
    do_read(8'h01, 8'h80, "R7 rail2 bit7");

    // R8 merge on
    merge_en = 1;
    rail_mismatch = 1; tick(); rail_mismatch = 0;
    do_read(8'h01, 8'h08, "R8 mismatch bit3");
    rail1_down = 1; tick(); rail1_down = 0;
    do_read(8'h01, 8'h80, "R8 rail1 or");
    rail2_down = 1; tick(); rail2_down = 0;
    do_read(8'h01, 8'h80, "R8 rail2 or");
    merge_en = 0;

    // R9 event in the read cycle
    @(negedge clk);
    rd_en = 1; rd_addr = 8'h00; ovc1 = 1;
    scb.push_back('{addr: 8'h00, exp: 8'h00, tag: "R9 read in event cycle"});
    @(negedge clk);
    rd_en = 0; ovc1 = 0;
    tick();
    do_read(8'h00, 8'h20, "R9 event kept");

    // R10 temperature
    temp_code = 8'h00; do_read(8'h02, 8'h00, "R10 temp min");
    temp_code = 8'hFF; do_read(8'h02, 8'hFF, "R10 temp max");
    temp_code = 8'h5A; do_read(8'h02, 8'h5A, "R10 temp mid");

    // R11 conversion split and snapshot
    adc1_val = 10'h2C7;
    do_read(8'h03, 8'hC7, "R11 conv1 low");
    adc1_val = 10'h155;
    do_read(8'h04, 8'h02, "R11 conv1 high from snapshot");
    do_read(8'h03, 8'h55, "R11 conv1 low new");
    do_read(8'h04, 8'h01, "R11 conv1 high new");
    adc2_val = 10'h3FF;
    do_read(8'h05, 8'hFF, "R11 conv2 low max");
    adc2_val = 10'h000;
    do_read(8'h06, 8'h03, "R11 conv2 high max held");
    do_read(8'h05, 8'h00, "R11 conv2 low min");
    do_read(8'h06, 8'h00, "R11 conv2 high min");

    // R12 unused addresses, no side effect
    ovc2 = 1; mon1 = 1; tick(); ovc2 = 0; mon1 = 0;
    do_read(8'h07, 8'h00, "R12 addr 07");
    do_read(8'hFF, 8'h00, "R12 addr FF");
    do_read(8'h00, 8'h10, "R12 fault flag survives");
    do_read(8'h01, 8'h02, "R12 chan flag survives");

    // R13 idle output zero
    tick();
    check_bit(rd_data == 8'h00, 1'b1, "R13 idle rd_data");

    repeat (3) tick();
    finish_run();
  end
endmodule